// File: doc/BRIEF.md
# Indirect Pointer Resolution Stage with Autoincrement

This stage sits between decode and execute in a pipeline for a machine with 12-bit words and a 15-bit address space. The address space is a 3-bit field above a 12-bit word. For an indirect instruction, the stage reads the pointer word at the instruction's initial address through a data-cache lookup port. It then forms the final operand address by placing the instruction's field bits above the pointer. When the lookup misses, the stage sends one line-fill command and holds the instruction until the lookup hits. Instructions that are not indirect pass straight through to the output register.

Some locations autoincrement. For these the stage adds one to the pointer modulo 4096, uses the new value as the address, and sends a single-word masked store that writes the new value back to the initial address. The caches snoop this store to update themselves. Instructions carry a generation tag, kept in Gray code and compared only for equality. An instruction is dropped when its tag matches neither the stage's own generation nor the global generation.

An incremented instruction may later be squashed downstream. In that case the downstream logic presents an undo request, and the stage sends a compensating store of the final pointer minus one. A Gray-coded store counter advances by two for each undo, which covers the original store and the undo. It advances by one for each commit that the downstream logic reports.

Top module: `idx_autoinc_stage`

## Requirements
- R1: After reset, out_valid is 0, st_valid and fill_valid are 0 while no request is present, and store_cnt_gray is 0.
- R2: A non-indirect, non-stale instruction is accepted while the output register is free, and one cycle later out_final_addr equals in_addr and out_autoinc is 0.
- R3: On a lookup miss of an indirect instruction, in_ready is 0 and fill_valid is 1 with fill_line equal to in_init_addr shifted right by 3. After one accepted fill, fill_valid stays 0 until the lookup hits.
- R4: An indirect instruction that is not autoincrement, on a hit, produces out_final_addr = in_dfield*4096 + lk_data one cycle later.
- R5: An autoincrement instruction on a hit sends a store in its acceptance cycle. The store has st_addr = in_init_addr, st_data = (lk_data+1) mod 4096, st_mask = 1 << in_init_addr[2:0] (bit i marks word i of the 8-word line) and st_undo = 0. One cycle later out_final_addr = in_dfield*4096 + that new pointer, and out_autoinc is 1.
- R6: An autoincrement instruction that hits while st_ready is 0 is not accepted (in_ready is 0), and no output appears.
- R7: An instruction whose in_gen differs from both the stage generation and glob_gen is consumed (in_ready is 1) with no store, no fill and no output. The stage generation becomes the tag of each instruction it accepts and starts at 0.
- R8: An undo request produces a store with st_addr = und_init_addr, st_data = (und_final_addr[11:0]-1) mod 4096, the matching one-hot mask and st_undo = 1. und_ready equals st_ready. An undo takes priority over an autoincrement store in the same cycle, and that instruction waits.
- R9: The store counter grows by 2 for each accepted undo and by 1 for each cmt_valid cycle. store_cnt_gray shows count XOR (count >> 1) in the cycle after.
- R10: While out_valid is 1 and out_ready is 0, the output holds its value and no new instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glob_gen | input | 4 | Global generation tag (Gray code) |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction consumed this cycle |
| in_gen | input | 4 | Instruction generation tag |
| in_indirect | input | 1 | Instruction needs a pointer read |
| in_autoinc | input | 1 | Pointer location autoincrements |
| in_init_addr | input | 15 | Address of the pointer word |
| in_dfield | input | 3 | Field placed above the pointer |
| in_addr | input | 15 | Final address of a direct instruction |
| out_valid | output | 1 | Resolved instruction present |
| out_ready | input | 1 | Downstream takes the instruction |
| out_gen | output | 4 | Generation tag passed on |
| out_autoinc | output | 1 | Instruction stored an incremented pointer |
| out_init_addr | output | 15 | Pointer address passed on for a possible undo |
| out_final_addr | output | 15 | Resolved operand address |
| lk_addr | output | 15 | Cache lookup address |
| lk_hit | input | 1 | Lookup hit |
| lk_data | input | 12 | Word returned on a hit |
| fill_valid | output | 1 | Line-fill command |
| fill_ready | input | 1 | Fill command taken |
| fill_line | output | 12 | Line number to fill |
| st_valid | output | 1 | Store command |
| st_ready | input | 1 | Store command taken |
| st_addr | output | 15 | Store word address |
| st_data | output | 12 | Store data |
| st_mask | output | 8 | One-hot word mask within the line |
| st_undo | output | 1 | Store is an undo |
| und_valid | input | 1 | Undo request for a squashed autoincrement |
| und_ready | output | 1 | Undo store taken |
| und_init_addr | input | 15 | Pointer address to restore |
| und_final_addr | input | 15 | Final address the squashed instruction used |
| cmt_valid | input | 1 | One committed autoincrement store |
| store_cnt_gray | output | 8 | Store counter in Gray code |

## Verification
The store, fill, ready and undo-acknowledge outputs are combinational. Their values are due in the cycle the stimulus is applied, so the bench checks them one time unit after it drives the inputs at the falling edge. The output register and the store counter change at the next rising edge, so the bench checks them at the following falling edge. The bench predicts pointers with a fixed arithmetic function of the lookup address that includes the 4095 wrap. It sweeps all field values and word offsets and computes every expected address, mask and Gray count from that function.

// File: rtl/idx_pkg.sv
package idx_pkg;
   typedef enum logic [1:0] {
      SRC_IDLE = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_UNDO = 2'd2
   } st_src_e;

   function automatic logic is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/idx_ptr_unit.sv
module idx_ptr_unit #(
   parameter int WORD_W  = 12,
   parameter int FIELD_W = 3,
   localparam int AW     = WORD_W + FIELD_W
) (
   input  logic [WORD_W-1:0]  ptr,
   input  logic               autoinc,
   input  logic [FIELD_W-1:0] dfield,
   input  logic [AW-1:0]      und_final,
   output logic [WORD_W-1:0]  new_ptr,
   output logic [AW-1:0]      final_addr,
   output logic [WORD_W-1:0]  und_ptr
);
   logic [WORD_W-1:0] used_ptr;

   // modulo 2**WORD_W arithmetic comes from the width itself
   always_comb begin
      new_ptr    = ptr + {{(WORD_W-1){1'b0}}, 1'b1};
      used_ptr   = autoinc ? new_ptr : ptr;
      final_addr = {dfield, used_ptr};
      und_ptr    = und_final[WORD_W-1:0] - {{(WORD_W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/idx_mask_gen.sv
module idx_mask_gen #(
   parameter int LINE_WORDS = 8,
   localparam int OFS_W     = $clog2(LINE_WORDS)
) (
   input  logic [OFS_W-1:0]      ofs,
   output logic [LINE_WORDS-1:0] mask
);
   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_bit
      assign mask[g] = (ofs == OFS_W'(g));
   end
endmodule

// File: rtl/idx_store_arb.sv
module idx_store_arb #(
   parameter int WORD_W     = 12,
   parameter int AW         = 15,
   parameter int LINE_WORDS = 8,
   parameter bit UNDO_FIRST = 1'b1
) (
   input  logic                  main_req,
   input  logic [AW-1:0]         main_addr,
   input  logic [WORD_W-1:0]     main_data,
   input  logic [LINE_WORDS-1:0] main_mask,
   input  logic                  undo_req,
   input  logic [AW-1:0]         undo_addr,
   input  logic [WORD_W-1:0]     undo_data,
   input  logic [LINE_WORDS-1:0] undo_mask,
   input  logic                  st_ready,
   output logic                  st_valid,
   output logic [AW-1:0]         st_addr,
   output logic [WORD_W-1:0]     st_data,
   output logic [LINE_WORDS-1:0] st_mask,
   output logic                  st_undo,
   output logic                  main_gnt,
   output logic                  undo_gnt
);
   import idx_pkg::*;
   st_src_e src;

   if (UNDO_FIRST) begin : g_undo_first
      always_comb src = undo_req ? SRC_UNDO : (main_req ? SRC_MAIN : SRC_IDLE);
   end else begin : g_main_first
      always_comb src = main_req ? SRC_MAIN : (undo_req ? SRC_UNDO : SRC_IDLE);
   end

   always_comb begin
      st_valid = (src != SRC_IDLE);
      st_undo  = (src == SRC_UNDO);
      st_addr  = st_undo ? undo_addr : main_addr;
      st_data  = st_undo ? undo_data : main_data;
      st_mask  = st_undo ? undo_mask : main_mask;
      main_gnt = (src == SRC_MAIN) && st_ready;
      undo_gnt = (src == SRC_UNDO) && st_ready;
   end
endmodule

// File: rtl/idx_gray_cnt.sv
module idx_gray_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_two,
   input  logic             add_one,
   output logic [CNT_W-1:0] gray
);
   logic [CNT_W-1:0] bin_q;

   if (CNT_W < 2) begin : g_bad_w
      $error("idx_gray_cnt: CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bin_q <= '0;
      else        bin_q <= bin_q + {{(CNT_W-2){1'b0}}, add_two, add_one};
   end

   assign gray = bin_q ^ (bin_q >> 1);
endmodule

// File: rtl/idx_autoinc_stage.sv
module idx_autoinc_stage #(
   parameter int WORD_W     = 12,
   parameter int FIELD_W    = 3,
   parameter int LINE_WORDS = 8,
   parameter int GEN_W      = 4,
   parameter int CNT_W      = 8,
   parameter bit UNDO_FIRST = 1'b1,
   parameter bit FILL_ONCE  = 1'b1,
   localparam int AW        = WORD_W + FIELD_W,
   localparam int OFS_W     = $clog2(LINE_WORDS),
   localparam int LINE_W    = AW - OFS_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [GEN_W-1:0]      glob_gen,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [GEN_W-1:0]      in_gen,
   input  logic                  in_indirect,
   input  logic                  in_autoinc,
   input  logic [AW-1:0]         in_init_addr,
   input  logic [FIELD_W-1:0]    in_dfield,
   input  logic [AW-1:0]         in_addr,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [GEN_W-1:0]      out_gen,
   output logic                  out_autoinc,
   output logic [AW-1:0]         out_init_addr,
   output logic [AW-1:0]         out_final_addr,
   output logic [AW-1:0]         lk_addr,
   input  logic                  lk_hit,
   input  logic [WORD_W-1:0]     lk_data,
   output logic                  fill_valid,
   input  logic                  fill_ready,
   output logic [LINE_W-1:0]     fill_line,
   output logic                  st_valid,
   input  logic                  st_ready,
   output logic [AW-1:0]         st_addr,
   output logic [WORD_W-1:0]     st_data,
   output logic [LINE_WORDS-1:0] st_mask,
   output logic                  st_undo,
   input  logic                  und_valid,
   output logic                  und_ready,
   input  logic [AW-1:0]         und_init_addr,
   input  logic [AW-1:0]         und_final_addr,
   input  logic                  cmt_valid,
   output logic [CNT_W-1:0]      store_cnt_gray
);
   import idx_pkg::*;

   if (!is_pow2(LINE_WORDS)) begin : g_bad_line
      $error("idx_autoinc_stage: LINE_WORDS must be a power of two");
   end
   if (GEN_W < 1 || WORD_W < 2 || FIELD_W < 1) begin : g_bad_w
      $error("idx_autoinc_stage: bad width parameter");
   end

   // ---------------- generation filter ----------------
   logic [GEN_W-1:0] stage_gen_q;
   logic             stale;
   assign stale = (in_gen != stage_gen_q) && (in_gen != glob_gen);

   // ---------------- pointer path ----------------
   logic              can_load, need_ptr, miss, main_req, accept;
   logic [WORD_W-1:0] new_ptr, und_ptr;
   logic [AW-1:0]     ind_final;
   logic              main_gnt, undo_gnt;

   assign can_load = !out_valid || out_ready;
   assign lk_addr  = in_init_addr;
   assign need_ptr = in_valid && !stale && in_indirect;
   assign miss     = need_ptr && !lk_hit;
   assign main_req = need_ptr && lk_hit && in_autoinc && can_load;

   idx_ptr_unit #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_ptr (
      .ptr        (lk_data),
      .autoinc    (in_autoinc),
      .dfield     (in_dfield),
      .und_final  (und_final_addr),
      .new_ptr    (new_ptr),
      .final_addr (ind_final),
      .und_ptr    (und_ptr)
   );

   // ---------------- store masks and arbitration ----------------
   logic [LINE_WORDS-1:0] main_mask, undo_mask;

   idx_mask_gen #(.LINE_WORDS(LINE_WORDS)) u_mask_main (
      .ofs  (in_init_addr[OFS_W-1:0]),
      .mask (main_mask)
   );
   idx_mask_gen #(.LINE_WORDS(LINE_WORDS)) u_mask_undo (
      .ofs  (und_init_addr[OFS_W-1:0]),
      .mask (undo_mask)
   );

   idx_store_arb #(
      .WORD_W(WORD_W), .AW(AW), .LINE_WORDS(LINE_WORDS), .UNDO_FIRST(UNDO_FIRST)
   ) u_arb (
      .main_req  (main_req),
      .main_addr (in_init_addr),
      .main_data (new_ptr),
      .main_mask (main_mask),
      .undo_req  (und_valid),
      .undo_addr (und_init_addr),
      .undo_data (und_ptr),
      .undo_mask (undo_mask),
      .st_ready  (st_ready),
      .st_valid  (st_valid),
      .st_addr   (st_addr),
      .st_data   (st_data),
      .st_mask   (st_mask),
      .st_undo   (st_undo),
      .main_gnt  (main_gnt),
      .undo_gnt  (undo_gnt)
   );
   assign und_ready = undo_gnt;

   // ---------------- acceptance ----------------
   always_comb begin
      if (!in_valid || stale)      in_ready = 1'b1;
      else if (!can_load)          in_ready = 1'b0;
      else if (!in_indirect)       in_ready = 1'b1;
      else if (!lk_hit)            in_ready = 1'b0;
      else if (in_autoinc)         in_ready = main_gnt;
      else                         in_ready = 1'b1;
   end
   assign accept = in_valid && !stale && in_ready;

   // ---------------- fill command ----------------
   assign fill_line = in_init_addr[AW-1:OFS_W];

   if (FILL_ONCE) begin : g_fill_once
      logic fill_pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          fill_pend_q <= 1'b0;
         else if (!miss)                      fill_pend_q <= 1'b0;
         else if (fill_valid && fill_ready)   fill_pend_q <= 1'b1;
      end
      assign fill_valid = miss && !fill_pend_q;
   end else begin : g_fill_repeat
      assign fill_valid = miss;
   end

   // ---------------- output register and stage generation ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_gen        <= '0;
         out_autoinc    <= 1'b0;
         out_init_addr  <= '0;
         out_final_addr <= '0;
         stage_gen_q    <= '0;
      end else begin
         if (accept) begin
            out_valid      <= 1'b1;
            out_gen        <= in_gen;
            out_autoinc    <= in_indirect && in_autoinc;
            out_init_addr  <= in_init_addr;
            out_final_addr <= in_indirect ? ind_final : in_addr;
            stage_gen_q    <= in_gen;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   // ---------------- store counter ----------------
   idx_gray_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_two (undo_gnt),
      .add_one (cmt_valid),
      .gray    (store_cnt_gray)
   );

   // ---------------- assertions ----------------
   AST_AUTOINC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !stale && in_indirect && in_autoinc && !st_ready) |-> !in_ready); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_final_addr) && $stable(out_gen))); // R10
   AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> ($countones(st_mask) == 1)); // R5
   AST_UNDO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_undo) |-> (st_data == WORD_W'(und_final_addr[WORD_W-1:0] - 1'b1)
                                 && st_addr == und_init_addr)); // R8
   AST_STALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && stale && !und_valid) |-> (!st_valid && !fill_valid && in_ready)); // R7
   AST_FILL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (FILL_ONCE && fill_valid && fill_ready && !accept) |=> (!fill_valid || !$stable(in_init_addr))); // R3
endmodule

// File: tb/idx_autoinc_stage_bench.sv
`timescale 1ns/1ps
module idx_autoinc_stage_bench;
   localparam int AW = 15;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  glob_gen;
   logic        in_valid, in_ready, in_indirect, in_autoinc;
   logic [3:0]  in_gen;
   logic [14:0] in_init_addr, in_addr;
   logic [2:0]  in_dfield;
   logic        out_valid, out_ready, out_autoinc;
   logic [3:0]  out_gen;
   logic [14:0] out_init_addr, out_final_addr, lk_addr;
   logic        lk_hit;
   logic [11:0] lk_data;
   logic        fill_valid, fill_ready;
   logic [11:0] fill_line;
   logic        st_valid, st_ready, st_undo;
   logic [14:0] st_addr;
   logic [11:0] st_data;
   logic [7:0]  st_mask;
   logic        und_valid, und_ready, cmt_valid;
   logic [14:0] und_init_addr, und_final_addr;
   logic [7:0]  store_cnt_gray;

   int checks = 0;
   int fails  = 0;
   int exp_cnt = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   // pointer contents are a fixed function of the address; offset 7 holds 4095
   function automatic logic [11:0] mem_word(input logic [14:0] a);
      if (a[2:0] == 3'd7) return 12'hFFF;
      return 12'((a * 29 + 3) & 12'hFFF);
   endfunction

   logic hit_en;
   assign lk_hit  = hit_en;
   assign lk_data = mem_word(lk_addr);

   idx_autoinc_stage u_idx_autoinc_stage (
      .clk(clk), .rst_n(rst_n), .glob_gen(glob_gen),
      .in_valid(in_valid), .in_ready(in_ready), .in_gen(in_gen),
      .in_indirect(in_indirect), .in_autoinc(in_autoinc),
      .in_init_addr(in_init_addr), .in_dfield(in_dfield), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_gen(out_gen),
      .out_autoinc(out_autoinc), .out_init_addr(out_init_addr),
      .out_final_addr(out_final_addr),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
      .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_data(st_data), .st_mask(st_mask), .st_undo(st_undo),
      .und_valid(und_valid), .und_ready(und_ready),
      .und_init_addr(und_init_addr), .und_final_addr(und_final_addr),
      .cmt_valid(cmt_valid), .store_cnt_gray(store_cnt_gray)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      in_valid = 0; in_indirect = 0; in_autoinc = 0;
      und_valid = 0; cmt_valid = 0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive_ins(input bit ind, input bit ai, input logic [14:0] ia,
                            input logic [2:0] df, input logic [14:0] da, input logic [3:0] g);
      in_valid = 1; in_indirect = ind; in_autoinc = ai;
      in_init_addr = ia; in_dfield = df; in_addr = da; in_gen = g;
   endtask

   function automatic logic [7:0] gray8(input int c);
      logic [7:0] b;
      b = 8'(c);
      return b ^ (b >> 1);
   endfunction

   initial begin : watchdog
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
   end

   initial begin : stim
      logic [11:0] p, np;
      rst_n = 0; glob_gen = 0; in_gen = 0; in_init_addr = 0; in_dfield = 0; in_addr = 0;
      out_ready = 1; fill_ready = 1; st_ready = 1; hit_en = 1;
      und_init_addr = 0; und_final_addr = 0;
      idle();
      repeat (3) step();
      rst_n = 1;
      #1;
      // R1 reset state
      check(!out_valid, "R1 out_valid", out_valid, 0);
      check(!st_valid && !fill_valid, "R1 st/fill idle", {st_valid, fill_valid}, 0);
      check(store_cnt_gray == 0, "R1 count", store_cnt_gray, 0);
      @(negedge clk);

      // R2 direct pass-through sweep
      for (int i = 0; i < 16; i++) begin
         logic [14:0] a;
         a = 15'((i * 2053 + 1) & 16'h7FFF);
         drive_ins(0, 0, 15'h1234, 3'd5, a, 0);
         #1 check(in_ready, "R2 ready", in_ready, 1);
         step(); idle();
         check(out_valid && out_final_addr == a && !out_autoinc, "R2 final", out_final_addr, a);
      end

      // R4 plain indirect sweep, every field and offset
      for (int i = 0; i < 64; i++) begin
         logic [14:0] ia;
         ia = 15'((i * 517 + i / 8) & 16'h7FFF);
         ia[2:0] = 3'(i);
         drive_ins(1, 0, ia, 3'(i / 8), 0, 0);
         #1 check(in_ready && !st_valid, "R4 ready", {in_ready, st_valid}, 2);
         step(); idle();
         check(out_final_addr == {3'(i / 8), mem_word(ia)}, "R4 final", out_final_addr,
               {3'(i / 8), mem_word(ia)});
      end

      // R5 autoincrement sweep including the 4095 wrap
      for (int i = 0; i < 64; i++) begin
         logic [14:0] ia;
         ia = 15'((i * 1201 + 77) & 16'h7FFF);
         ia[2:0] = 3'(i + i / 8);
         p  = mem_word(ia);
         np = 12'((p + 1) & 12'hFFF);
         drive_ins(1, 1, ia, 3'(i % 8), 0, 0);
         #1;
         check(in_ready && st_valid && !st_undo && st_addr == ia, "R5 store addr", st_addr, ia);
         check(st_data == np && st_mask == (8'd1 << ia[2:0]), "R5 store data/mask",
               {st_data, st_mask}, {np, 8'd1 << ia[2:0]});
         step(); idle();
         check(out_autoinc && out_final_addr == {3'(i % 8), np}, "R5 final", out_final_addr,
               {3'(i % 8), np});
      end

      // R3 miss with single fill, then hit
      hit_en = 0;
      drive_ins(1, 0, 15'h2A5B, 3'd2, 0, 0);
      #1 check(fill_valid && !in_ready && fill_line == 12'(15'h2A5B >> 3), "R3 fill",
               fill_line, 15'h2A5B >> 3);
      step();
      check(!fill_valid && !out_valid, "R3 fill once", fill_valid, 0);
      step();
      check(!fill_valid, "R3 fill still once", fill_valid, 0);
      hit_en = 1;
      #1 check(in_ready, "R3 hit ready", in_ready, 1);
      step(); idle();
      check(out_final_addr == {3'd2, mem_word(15'h2A5B)}, "R3 after fill", out_final_addr,
            {3'd2, mem_word(15'h2A5B)});
      step();

      // R6 store port busy
      st_ready = 0;
      drive_ins(1, 1, 15'h0107, 3'd1, 0, 0);
      #1 check(!in_ready, "R6 stall", in_ready, 0);
      step();
      check(!out_valid, "R6 no output", out_valid, 0);
      st_ready = 1;
      #1 check(in_ready, "R6 release", in_ready, 1);
      step(); idle();
      check(out_final_addr == {3'd1, 12'h000}, "R6 wrap final", out_final_addr, {3'd1, 12'h000});
      step();

      // R7 generation filter
      glob_gen = 4'd5;
      drive_ins(1, 1, 15'h0300, 3'd0, 0, 4'd3);
      #1 check(in_ready && !st_valid && !fill_valid, "R7 stale drop", {in_ready, st_valid}, 2);
      step(); idle();
      check(!out_valid, "R7 no output", out_valid, 0);
      drive_ins(0, 0, 0, 0, 15'h0042, 4'd5);
      step(); idle();
      check(out_valid && out_gen == 4'd5, "R7 global gen accepted", out_gen, 5);
      glob_gen = 4'd6;
      drive_ins(0, 0, 0, 0, 15'h0043, 4'd5);
      step(); idle();
      check(out_valid && out_final_addr == 15'h0043, "R7 stage gen accepted", out_final_addr, 15'h43);
      drive_ins(0, 0, 0, 0, 15'h0044, 4'd0);
      step(); idle();
      check(!out_valid, "R7 old gen dropped", out_valid, 0);
      in_gen = 4'd6; glob_gen = 4'd6;

      // R8 undo stores and R9 counting
      for (int i = 0; i < 8; i++) begin
         logic [14:0] ua, uf;
         ua = 15'(i * 911 + 5);
         uf = 15'(i * 4099);
         und_valid = 1; und_init_addr = ua; und_final_addr = uf;
         #1;
         check(st_valid && st_undo && und_ready && st_addr == ua, "R8 undo addr", st_addr, ua);
         check(st_data == 12'((uf[11:0] - 1) & 12'hFFF) && st_mask == (8'd1 << ua[2:0]),
               "R8 undo data", st_data, (uf[11:0] - 1) & 12'hFFF);
         step(); idle();
         exp_cnt += 2;
         check(store_cnt_gray == gray8(exp_cnt), "R9 count undo", store_cnt_gray, gray8(exp_cnt));
      end
      // R8 undo wins over an autoinc store; st_ready low blocks the undo
      und_valid = 1; und_init_addr = 15'h0011; und_final_addr = 15'h0000;
      drive_ins(1, 1, 15'h0222, 3'd0, 0, 4'd6);
      #1 check(st_undo && !in_ready && st_data == 12'hFFF, "R8 priority", {st_undo, in_ready}, 2);
      st_ready = 0;
      #1 check(!und_ready, "R8 undo waits", und_ready, 0);
      st_ready = 1;
      step(); und_valid = 0; exp_cnt += 2;
      #1 check(in_ready && !st_undo, "R8 instr after undo", in_ready, 1);
      step(); idle();
      check(out_autoinc, "R8 instr done", out_autoinc, 1);
      for (int i = 0; i < 5; i++) begin
         cmt_valid = 1;
         step(); exp_cnt++;
         check(store_cnt_gray == gray8(exp_cnt), "R9 count commit", store_cnt_gray, gray8(exp_cnt));
      end
      cmt_valid = 0;

      // R10 backpressure
      out_ready = 0;
      drive_ins(0, 0, 0, 0, 15'h0777, 4'd6);
      step();
      drive_ins(0, 0, 0, 0, 15'h0555, 4'd6);
      #1 check(!in_ready, "R10 blocked", in_ready, 0);
      step();
      check(out_valid && out_final_addr == 15'h0777, "R10 hold", out_final_addr, 15'h0777);
      out_ready = 1;
      step(); idle();
      check(out_final_addr == 15'h0555, "R10 next", out_final_addr, 15'h0555);
      step();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule